// File: doc/BRIEF.md
# Cascadable Programmable Pulse Generator

This block builds pulse-width-modulated waveforms from eight 8-bit down-counters grouped into four pairs. Every counter has two reload values: one sets how long its output stays low, the other how long it stays high. The counter runs a phase down to zero, then loads the reload value of the opposite phase and flips its level. Each phase lasts the reload value plus one count-clock ticks. Each counter takes its ticks from the system clock, from the system clock divided by 2, 4, 8 or 16, or from a slow external tick.

A pair can run in one of three ways. In split mode its two counters run on their own. In wide mode the two counters form one 16-bit counter, with the odd counter's reload values as the upper byte. In prescaler mode the even counter divides the count clock and clocks the odd counter. Each pair drives one waveform pin, always taken from its odd counter. Each counter has an interrupt flag that is set each time it reloads from high to low. Software sets up the block through a write-only register port and clears a flag by writing zero to it.

Top module: `casc_pwm`

## Requirements
- R1: A write with `wr_en` high goes to channel `wr_addr[4:2]`, field `wr_addr[1:0]`: 0 low-width reload, 1 high-width reload, 2 control, 3 flag. Control bits: [0] run enable, [1] pin enable (taken from the odd channel of a pair), [4:2] clock select, [6:5] pair mode (taken from the even channel of a pair: 0 split, 1 wide, 2 prescaler; 3 acts as split).
- R2: In split mode each channel alternates low and high phases of (low reload + 1) and (high reload + 1) ticks. Pin p shows the level of channel 2p+1. Channel 2p runs on its own and is visible only through its flag.
- R3: Clock select 0 gives a tick every system clock, 1 to 4 a tick every 2, 4, 8 or 16 clocks, 5 a tick on each cycle in which `slow_tick` is high, and 6 or 7 no ticks, so the counter and the level freeze.
- R4: In wide mode the phases last ({odd low reload, even low reload} + 1) and ({odd high reload, even high reload} + 1) ticks. Run enable and pin enable come from the odd channel, the clock select from the even channel, and the even channel's flag is never set.
- R5: In prescaler mode the even channel reloads only its low-width value and never sets its flag. Each of its underflows is one tick of the odd channel, so the odd phase lasts (reload + 1) × (even low reload + 1) × divider clocks.
- R6: Setting run enable starts the channel with its level low and its low-width value loaded. The pin is low for exactly low reload + 2 sampled cycles after the enabling write at the system clock. Clearing run enable stops the channel with its level low, and no further flag is set.
- R7: A reload value written during a phase does not change that phase. It takes effect at the next phase that uses it.
- R8: A channel's flag (`irq` bit) is set at each high-to-low reload and not at a low-to-high reload. A write of data bit 0 = 0 to field 3 clears it; a write of 1 leaves it unchanged.
- R9: With pin enable clear, the pin is held low while the channel keeps counting and setting its flag.
- R10: After reset all registers are zero and all pins and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow timebase tick, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Channel (bits 4:2) and field (bits 1:0) |
| wr_data | input | 8 | Write data |
| wave | output | 4 | One waveform pin per pair |
| irq | output | 8 | Interrupt flag per channel |

## Verification
A counter loaded with the wrong value, or one that misses or gains a tick, shows as a wrong pin phase length within one phase of the fault. The bench therefore measures whole high and low phases in cycles and compares them with the reload arithmetic for each mode and clock select. A level register that starts in the wrong state shows within the first low phase after the enabling write. A flag set on the wrong reload, or not cleared, shows at the `irq` port on the very next falling or rising pin edge. A prescaler chain that passes the wrong ticks scales the odd channel's phases by the wrong factor, and a single measured phase exposes that.

// File: rtl/casc_pwm_pkg.sv
`timescale 1ns/1ps
package casc_pwm_pkg;
  localparam int NDIV     = 4;        // divided ticks /2 .. /2**NDIV
  localparam int SEL_W    = 3;
  localparam int SEL_SLOW = NDIV + 1;
  localparam int CTRL_W   = 7;
  localparam int CB_EN    = 0;
  localparam int CB_OE    = 1;
  localparam int CB_SEL   = 2;
  localparam int CB_MODE  = 5;
  localparam logic [1:0] FLD_LO   = 2'd0;
  localparam logic [1:0] FLD_HI   = 2'd1;
  localparam logic [1:0] FLD_CTRL = 2'd2;
  localparam logic [1:0] FLD_FLAG = 2'd3;

  typedef enum logic [1:0] {
    PM_SPLIT = 2'd0,
    PM_WIDE  = 2'd1,
    PM_PRESC = 2'd2
  } pair_mode_e;

  function automatic pair_mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'd1:    return PM_WIDE;
      2'd2:    return PM_PRESC;
      default: return PM_SPLIT;
    endcase
  endfunction

  // choose the count tick of one channel
  function automatic logic pick_tick(input logic [SEL_W-1:0] sel,
                                     input logic [NDIV:0] tk,
                                     input logic slow);
    logic t;
    t = 1'b0;
    for (int k = 0; k <= NDIV; k++)
      if (sel == SEL_W'(k)) t = tk[k];
    if (sel == SEL_W'(SEL_SLOW)) t = slow;
    return t;
  endfunction
endpackage

// File: rtl/casc_pwm_tickgen.sv
`timescale 1ns/1ps
module casc_pwm_tickgen
  import casc_pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic [NDIV:0] tick_vec
);
  logic [NDIV-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + NDIV'(1);
  end

  assign tick_vec[0] = 1'b1;
  for (genvar k = 1; k <= NDIV; k++) begin : g_div
    assign tick_vec[k] = &div_cnt[k-1:0];
  end
endmodule

// File: rtl/casc_pwm_regs.sv
`timescale 1ns/1ps
module casc_pwm_regs
  import casc_pwm_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8,
  parameter int AW  = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  wr_addr,
  input  logic [CW-1:0]                  wr_data,
  output logic [NCH-1:0][CW-1:0]         lo_rl,
  output logic [NCH-1:0][CW-1:0]         hi_rl,
  output logic [NCH-1:0]                 ch_en,
  output logic [NCH-1:0]                 pin_en,
  output logic [NCH-1:0][SEL_W-1:0]      csel,
  output logic [NCH-1:0][1:0]            mode_bits,
  output logic [NCH-1:0]                 flag_clr
);
  localparam int CIW = AW - 2;

  logic [1:0] fld;
  assign fld = wr_addr[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [CW-1:0]     lo_q, hi_q;
    logic [CTRL_W-1:0] ctrl_q;

    assign hit = wr_en && (wr_addr[AW-1:2] == CIW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q   <= '0;
        hi_q   <= '0;
        ctrl_q <= '0;
      end else if (hit) begin
        case (fld)
          FLD_LO:   lo_q   <= wr_data;
          FLD_HI:   hi_q   <= wr_data;
          FLD_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
          default:  ;
        endcase
      end
    end

    assign lo_rl[c]     = lo_q;
    assign hi_rl[c]     = hi_q;
    assign ch_en[c]     = ctrl_q[CB_EN];
    assign pin_en[c]    = ctrl_q[CB_OE];
    assign csel[c]      = ctrl_q[CB_SEL +: SEL_W];
    assign mode_bits[c] = ctrl_q[CB_MODE +: 2];
    assign flag_clr[c]  = hit && (fld == FLD_FLAG) && !wr_data[0];
  end
endmodule

// File: rtl/casc_pwm_pair.sv
`timescale 1ns/1ps
module casc_pwm_pair
  import casc_pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NDIV:0]         tick_vec,
  input  logic                  slow_tick,
  input  logic [1:0][CW-1:0]    lo_rl,
  input  logic [1:0][CW-1:0]    hi_rl,
  input  logic [1:0]            ch_en,
  input  logic [1:0][SEL_W-1:0] csel,
  input  logic [1:0]            mode_raw,
  input  logic                  pin_en,
  input  logic [1:0]            flag_clr,
  output logic                  wave,
  output logic [1:0]            flag,
  output logic [1:0]            lvl,
  output logic [1:0]            start,
  output logic [1:0]            uflow,
  output logic [1:0]            hl_evt,
  output logic [1:0]            active,
  output logic [1:0]            tick_ch,
  output logic [1:0]            pmode
);
  localparam int WW = 2 * CW;

  // reload for the phase that follows the current level
  function automatic logic [CW-1:0] next_rl(input logic cur_high,
                                            input logic [CW-1:0] lo,
                                            input logic [CW-1:0] hi);
    return cur_high ? lo : hi;
  endfunction

  function automatic logic [WW-1:0] next_rl_w(input logic cur_high,
                                              input logic [WW-1:0] lo,
                                              input logic [WW-1:0] hi);
    return cur_high ? lo : hi;
  endfunction

  pair_mode_e mode;
  logic       wide, presc;
  logic [CW-1:0] cnt_e, cnt_o, nx_e, nx_o;
  logic          lvl_e, lvl_o, nx_lvl_e, nx_lvl_o;
  logic          run_e, run_o;
  logic          en_e, en_o, tk_e, tk_o, st_e, st_o, uf_e, uf_o;
  logic          flag_e, flag_o;
  logic [WW-1:0] wide_cnt, wide_lo, wide_hi;

  assign mode  = decode_mode(mode_raw);
  assign wide  = (mode == PM_WIDE);
  assign presc = (mode == PM_PRESC);

  assign wide_cnt = {cnt_o, cnt_e};
  assign wide_lo  = {lo_rl[1], lo_rl[0]};
  assign wide_hi  = {hi_rl[1], hi_rl[0]};

  assign en_e = wide ? ch_en[1] : ch_en[0];
  assign en_o = ch_en[1];
  assign st_e = en_e & ~run_e;
  assign st_o = en_o & ~run_o;

  assign tk_e = pick_tick(csel[0], tick_vec, slow_tick);
  assign uf_e = ~wide & tk_e & run_e & en_e & (cnt_e == '0);
  assign tk_o = wide  ? tk_e :
                presc ? uf_e : pick_tick(csel[1], tick_vec, slow_tick);
  assign uf_o = tk_o & run_o & en_o &
                (wide ? (wide_cnt == '0) : (cnt_o == '0));

  always_comb begin
    nx_e     = cnt_e;
    nx_o     = cnt_o;
    nx_lvl_e = lvl_e;
    nx_lvl_o = lvl_o;
    if (wide) begin
      nx_lvl_e = 1'b0;
      if (!en_o) begin
        nx_lvl_o = 1'b0;
      end else if (st_o) begin
        {nx_o, nx_e} = wide_lo;
        nx_lvl_o     = 1'b0;
      end else if (uf_o) begin
        {nx_o, nx_e} = next_rl_w(lvl_o, wide_lo, wide_hi);
        nx_lvl_o     = ~lvl_o;
      end else if (tk_o) begin
        {nx_o, nx_e} = wide_cnt - WW'(1);
      end
    end else begin
      // even counter: channel or prescaler
      if (!en_e) begin
        nx_lvl_e = 1'b0;
      end else if (st_e) begin
        nx_e     = lo_rl[0];
        nx_lvl_e = 1'b0;
      end else if (uf_e) begin
        nx_e     = presc ? lo_rl[0] : next_rl(lvl_e, lo_rl[0], hi_rl[0]);
        nx_lvl_e = presc ? 1'b0 : ~lvl_e;
      end else if (tk_e) begin
        nx_e = cnt_e - CW'(1);
      end
      // odd counter
      if (!en_o) begin
        nx_lvl_o = 1'b0;
      end else if (st_o) begin
        nx_o     = lo_rl[1];
        nx_lvl_o = 1'b0;
      end else if (uf_o) begin
        nx_o     = next_rl(lvl_o, lo_rl[1], hi_rl[1]);
        nx_lvl_o = ~lvl_o;
      end else if (tk_o) begin
        nx_o = cnt_o - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_e  <= '0;
      cnt_o  <= '0;
      lvl_e  <= 1'b0;
      lvl_o  <= 1'b0;
      run_e  <= 1'b0;
      run_o  <= 1'b0;
      flag_e <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      cnt_e  <= nx_e;
      cnt_o  <= nx_o;
      lvl_e  <= nx_lvl_e;
      lvl_o  <= nx_lvl_o;
      run_e  <= en_e;
      run_o  <= en_o;
      flag_e <= (uf_e & lvl_e) | (flag_e & ~flag_clr[0]);
      flag_o <= (uf_o & lvl_o) | (flag_o & ~flag_clr[1]);
    end
  end

  assign wave    = pin_en & lvl_o;
  assign flag    = {flag_o, flag_e};
  assign lvl     = {lvl_o, lvl_e};
  assign start   = {st_o, st_e};
  assign uflow   = {uf_o, uf_e};
  assign hl_evt  = {uf_o & lvl_o, uf_e & lvl_e};
  assign active  = {run_o, run_e};
  assign tick_ch = {tk_o, tk_e};
  assign pmode   = mode;
endmodule

// File: rtl/casc_pwm.sv
`timescale 1ns/1ps
module casc_pwm
  import casc_pwm_pkg::*;
#(
  parameter  int NCH   = 8,
  parameter  int CW    = 8,
  localparam int AW    = $clog2(NCH) + 2,
  localparam int NPAIR = NCH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  output logic [NPAIR-1:0] wave,
  output logic [NCH-1:0]   irq
);
  logic [NDIV:0]                tick_vec;
  logic [NCH-1:0][CW-1:0]       lo_rl, hi_rl;
  logic [NCH-1:0]               ch_en, pin_en, flag_clr;
  logic [NCH-1:0][SEL_W-1:0]    csel;
  logic [NCH-1:0][1:0]          mode_bits;
  // named internal events, observed by the checker
  logic [NCH-1:0]               ch_lvl, ch_start, ch_uflow, ch_hl, ch_active, ch_tick;
  logic [NPAIR-1:0][1:0]        pr_mode;

  casc_pwm_tickgen u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_vec (tick_vec)
  );

  casc_pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .lo_rl     (lo_rl),
    .hi_rl     (hi_rl),
    .ch_en     (ch_en),
    .pin_en    (pin_en),
    .csel      (csel),
    .mode_bits (mode_bits),
    .flag_clr  (flag_clr)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    casc_pwm_pair #(.CW(CW)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_vec  (tick_vec),
      .slow_tick (slow_tick),
      .lo_rl     (lo_rl[2*p+1:2*p]),
      .hi_rl     (hi_rl[2*p+1:2*p]),
      .ch_en     (ch_en[2*p+1:2*p]),
      .csel      (csel[2*p+1:2*p]),
      .mode_raw  (mode_bits[2*p]),
      .pin_en    (pin_en[2*p+1]),
      .flag_clr  (flag_clr[2*p+1:2*p]),
      .wave      (wave[p]),
      .flag      (irq[2*p+1:2*p]),
      .lvl       (ch_lvl[2*p+1:2*p]),
      .start     (ch_start[2*p+1:2*p]),
      .uflow     (ch_uflow[2*p+1:2*p]),
      .hl_evt    (ch_hl[2*p+1:2*p]),
      .active    (ch_active[2*p+1:2*p]),
      .tick_ch   (ch_tick[2*p+1:2*p]),
      .pmode     (pr_mode[p])
    );
  end
endmodule

// File: rtl/casc_pwm_chk.sv
`timescale 1ns/1ps
module casc_pwm_chk
  import casc_pwm_pkg::*;
#(
  parameter  int NCH   = 8,
  localparam int NPAIR = NCH / 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPAIR-1:0]      wave,
  input logic [NCH-1:0]        irq,
  input logic [NCH-1:0]        lvl,
  input logic [NCH-1:0]        start,
  input logic [NCH-1:0]        uflow,
  input logic [NCH-1:0]        hl_evt,
  input logic [NCH-1:0]        active,
  input logic [NCH-1:0]        tick_ch,
  input logic [NPAIR-1:0][1:0] pmode
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> $past(hl_evt[c]));
    // R6
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start[c] |=> !lvl[c]);
    // R2
    rise_on_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl[c]) |-> $past(uflow[c]));
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_p
    // R9
    pin_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wave[p] |-> active[2*p+1]);
    // R5
    presc_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode[p] == PM_PRESC && tick_ch[2*p+1]) |-> uflow[2*p]);
  end
endmodule

bind casc_pwm casc_pwm_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wave    (wave),
  .irq     (irq),
  .lvl     (ch_lvl),
  .start   (ch_start),
  .uflow   (ch_uflow),
  .hl_evt  (ch_hl),
  .active  (ch_active),
  .tick_ch (ch_tick),
  .pmode   (pr_mode)
);

// File: tb/test_casc_pwm.sv
`timescale 1ns/1ps
module test_casc_pwm;
  localparam int NCH = 8, CW = 8, AW = 5, NPAIR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NPAIR-1:0] wave;
  logic [NCH-1:0] irq;
  int checks = 0;
  int errors = 0;
  logic [2:0] stc = '0;

  casc_pwm i_casc_pwm (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wave(wave), .irq(irq)
  );

  always #2 clk = ~clk;   // 250 MHz

  // slow tick: one clock high every 8 clocks
  always @(negedge clk) begin
    stc <= stc + 3'd1;
    slow_tick <= (stc == 3'd7);
  end

  task automatic chk(input int act, input int exp, input string msg);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input int p, input logic v);
    int g = 0;
    while (wave[p] !== v && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(input int p, output int hi, output int lo);
    wait_level(p, 1'b0);
    wait_level(p, 1'b1);
    hi = 0;
    while (wave[p] === 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
    lo = 0;
    while (wave[p] === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk(int'(wave), 0, "R10 pins low after reset");
    chk(int'(irq), 0, "R10 flags low after reset");
  endtask

  task automatic t_start_split();
    int z, h, l;
    wr(0, 1); wr(1, 1); wr(2, 1);          // ch0: lo 1 hi 1, run, sysclk
    wr(4, 3); wr(5, 5);                    // ch1: lo 3 hi 5
    wr(6, 3);                              // ch1: run + pin
    z = 0;
    while (wave[0] === 1'b0 && z < 100) begin z++; @(negedge clk); end
    chk(z, 5, "R6 low phase first, lo+2 samples after enable");
    measure(0, h, l);
    chk(h, 6, "R2 high phase = hi+1");
    chk(l, 4, "R2 low phase = lo+1");
    chk(int'(irq[0]), 1, "R2 even channel runs independently");
  endtask

  task automatic t_reload();
    int h, l;
    wait_level(0, 1'b0);
    wait_level(0, 1'b1);
    h = 1;
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 8'd9;
    @(negedge clk);
    wr_en = 1'b0;
    while (wave[0] === 1'b1 && h < 100) begin h++; @(negedge clk); end
    chk(h, 6, "R7 running high phase keeps old width");
    measure(0, h, l);
    chk(h, 10, "R7 next high phase uses new width");
    chk(l, 4, "R7 low phase unchanged");
  endtask

  task automatic t_flags();
    wait_level(0, 1'b0);
    wait_level(0, 1'b1);
    wr(7, 0);
    chk(int'(irq[1]), 0, "R8 flag cleared by writing 0");
    wait_level(0, 1'b0);
    chk(int'(irq[1]), 1, "R8 flag set on high-to-low reload");
    wr(7, 1);
    chk(int'(irq[1]), 1, "R8 writing 1 leaves flag");
    wr(7, 0);
    wait_level(0, 1'b1);
    chk(int'(irq[1]), 0, "R8 low-to-high reload sets no flag");
  endtask

  task automatic t_pin_off();
    int bad = 0;
    wait_level(0, 1'b1);
    wr(7, 0);
    wr(6, 1);                              // run, pin off
    for (int i = 0; i < 40; i++) begin
      if (wave[0] !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad, 0, "R9 pin held low with pin enable clear");
    chk(int'(irq[1]), 1, "R9 channel keeps running");
    wr(6, 3);
  endtask

  task automatic t_disable();
    int bad = 0;
    wr(6, 2);                              // run off
    @(negedge clk);
    wr(7, 0);
    for (int i = 0; i < 60; i++) begin
      if (wave[0] !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad, 0, "R6 stopped channel keeps pin low");
    chk(int'(irq[1]), 0, "R6 stopped channel sets no flag");
  endtask

  task automatic t_clksel();
    int h, l, moves;
    logic prev;
    wr(12, 1); wr(13, 2);                  // ch3: lo 1 hi 2
    wr(14, (2 << 2) | 3);                  // /4
    measure(1, h, l);
    chk(h, 12, "R3 select 2 high phase");
    chk(l, 8, "R3 select 2 low phase");
    wr(14, (4 << 2) | 3);                  // /16
    measure(1, h, l);
    chk(h, 48, "R3 select 4 high phase");
    chk(l, 32, "R3 select 4 low phase");
    wr(14, (5 << 2) | 3);                  // slow tick
    measure(1, h, l);
    chk(h, 24, "R3 slow tick high phase");
    chk(l, 16, "R3 slow tick low phase");
    wr(14, (6 << 2) | 3);                  // no ticks
    @(negedge clk);
    prev = wave[1];
    moves = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wave[1] !== prev) moves++;
      prev = wave[1];
    end
    chk(moves, 0, "R3 select 6 freezes pin");
  endtask

  task automatic t_wide();
    int h, l;
    wr(16, 2); wr(17, 32);                 // ch4 low bytes
    wr(20, 1); wr(21, 0);                  // ch5 high bytes
    wr(18, 1 << 5);                        // ch4: wide mode, sysclk
    wr(22, 3);                             // ch5: run + pin
    measure(2, h, l);
    chk(h, 33, "R4 wide high phase");
    chk(l, 259, "R4 wide low phase");
    chk(int'(irq[4]), 0, "R4 even flag unused in wide mode");
    chk(int'(irq[5]), 1, "R4 wide flag on odd channel");
  endtask

  task automatic t_presc();
    int h, l;
    wr(24, 2);                             // ch6 prescale lo 2
    wr(26, (2 << 5) | (1 << 2) | 1);       // ch6: prescaler mode, /2, run
    wr(28, 1); wr(29, 3);                  // ch7 lo 1 hi 3
    wr(30, 3);
    measure(3, h, l);
    chk(h, 24, "R5 prescaled high phase");
    chk(l, 12, "R5 prescaled low phase");
    chk(int'(irq[6]), 0, "R5 prescaler sets no flag");
    chk(int'(irq[7]), 1, "R5 odd flag set");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();     // R10
    t_start_split(); // R2, R6
    t_reload();    // R7
    t_flags();     // R8
    t_pin_off();   // R9
    t_disable();   // R6
    t_clksel();    // R3, R1
    t_wide();      // R4
    t_presc();     // R5
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule